// File: doc/BRIEF.md
# Three-Wire Register Access Serial Master

This block is the controller-side engine that reads and writes 8-bit registers inside a radio transceiver over a half-duplex serial link. The link has a serial clock, one shared bidirectional data line, an active-low register select and a second active-low select for the transceiver's packet buffer. Packet-buffer bursts are not supported. The buffer select is simply held inactive.

The user side raises a one-cycle request while the block is idle. The request carries a read/write flag, a 7-bit register address and the write data. The block then shifts out a 16-bit frame. The frame is the direction bit, then the address, then eight data bits, all most significant bit first. The master sets each outgoing bit on the serial clock's falling edge, and the transceiver samples it on the rising edge. In a read, the master stops driving the data line partway through the high phase of the last address bit. It then captures the transceiver's eight reply bits on the next eight rising edges.

Half-period guard times surround the clocking on both sides of the select edges. The serial clock rate comes from a divider parameter that counts system-clock cycles per half period. The data pin is exposed as separate output, output-enable and input signals, so a pad ring can build the tri-state buffer.

Top module: `rfreg_spi_master`

## Requirements
- R1: The buffer select `fifo_sel_n_o` stays high at all times, so it is never low while `reg_sel_n_o` is low.
- R2: After reset and between frames, `reg_sel_n_o` is high, `ser_clk_o` is low, and `dat_oe_o`, `busy_o` and `done_o` are low.
- R3: Each frame has exactly 16 rising edges of `ser_clk_o`. The bits seen on those edges are the direction bit (1 = read, 0 = write), then `addr_i[6:0]`, then eight data bits, all MSB first. For a write, the data bits are `wdata_i[7:0]`.
- R4: `dat_o` changes only while `ser_clk_o` is low. The first bit is presented when `reg_sel_n_o` falls, and each later bit is presented on a falling edge of `ser_clk_o`.
- R5: Each high phase and each low phase of `ser_clk_o` lasts exactly HALF_DIV system cycles. The default of 13 gives a 208 ns period at 125 MHz, which is under 5 MHz.
- R6: The first rising edge of `ser_clk_o` comes HALF_DIV cycles after `reg_sel_n_o` falls. `reg_sel_n_o` rises HALF_DIV cycles after the last falling edge. `ser_clk_o` is low at both select edges.
- R7: In a read, `dat_oe_o` falls HALF_DIV/2+1 cycles after the rising edge that carries address bit 0, which is before the next falling edge. It stays low until the frame ends. The eight rising edges that follow load `dat_i` into `rdata_o`, MSB first.
- R8: In a write, `dat_oe_o` is high from the fall of `reg_sel_n_o` until its rise.
- R9: A request is taken only in a cycle where `busy_o` is low. `req_i` has no effect while `busy_o` is high, including during the `done_o` cycle.
- R10: `done_o` is a one-cycle pulse in the first cycle with `reg_sel_n_o` high again. In that cycle, `rdata_o` holds the read byte, or zero after a write. `busy_o` falls in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a register access (taken when idle) |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 7 | Register address |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid with done_o |
| ser_clk_o | output | 1 | Serial clock to the transceiver |
| reg_sel_n_o | output | 1 | Register select, active low |
| fifo_sel_n_o | output | 1 | Packet-buffer select, held high |
| dat_o | output | 1 | Serial data out |
| dat_oe_o | output | 1 | Serial data output enable |
| dat_i | input | 1 | Serial data in |

## Verification
The hardest case to reach from the ports is a new request that lands while the engine is still finishing. This covers both a request raised mid-frame and a request held high through the single `done_o` cycle. In both, a wrong acceptance would only show up as a shifted waveform, hundreds of cycles later.

The stimulus pulses `req_i` with a different read frame in the middle of a write. It also holds `req_i` high across two whole frames. A per-cycle timeline model predicts every output, including the mid-phase release of the data driver in reads. A transceiver model on the serial pins decodes the direction bit by itself and returns a known byte.

// File: rtl/rfreg_spi_pkg.sv
`timescale 1ns/1ps
package rfreg_spi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/rfreg_phase_timer.sv
`timescale 1ns/1ps
module rfreg_phase_timer #(
  parameter int HALF_DIV = 13,
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o
);
  assign tick_o = (cnt_o == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_o <= '0;
    else if (restart_i || tick_o) cnt_o <= '0;
    else                          cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_o) < HALF_DIV); // R5
endmodule

// File: rtl/rfreg_frame_shift.sv
`timescale 1ns/1ps
module rfreg_frame_shift #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8,
  localparam int FRAME_W = 1 + ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              shift_i,
  input  logic              cap_i,
  input  logic              dat_i,
  output logic              bit_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [FRAME_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      frame_q <= '0;
    else if (load_i)  frame_q <= {rd_i, addr_i, wdata_i};
    else if (shift_i) frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (load_i) rdata_o <= '0;
    else if (cap_i)  rdata_o <= {rdata_o[DATA_W-2:0], dat_i};
  end

  assign bit_o = frame_q[FRAME_W-1];
endmodule

// File: rtl/rfreg_seq.sv
`timescale 1ns/1ps
module rfreg_seq
  import rfreg_spi_pkg::*;
#(
  parameter int HALF_DIV = 13,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  localparam int CMD_W   = 1 + ADDR_W,
  localparam int FRAME_W = CMD_W + DATA_W,
  localparam int BIT_W   = $clog2(FRAME_W),
  localparam int CNT_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  output logic             restart_o,
  output logic             load_o,
  output logic             shift_o,
  output logic             cap_o,
  output logic             ser_clk_o,
  output logic             sel_n_o,
  output logic             oe_o,
  output logic             busy_o,
  output logic             done_o
);
  seq_state_e       state_q;
  logic [BIT_W-1:0] bit_q;
  logic             rd_q;
  logic             accept, last_bit, release_pt;

  assign accept     = (state_q == ST_IDLE) && req_i;
  assign last_bit   = (bit_q == BIT_W'(FRAME_W - 1));
  // drive released mid-high of the final address bit, before its falling edge
  assign release_pt = (state_q == ST_HIGH) && rd_q && (bit_q == BIT_W'(CMD_W - 1))
                      && (cnt_i == CNT_W'(HALF_DIV / 2));
  assign restart_o  = accept;
  assign load_o     = accept;
  assign shift_o    = (state_q == ST_HIGH) && tick_i;
  assign cap_o      = (state_q == ST_LOW) && tick_i && rd_q && (int'(bit_q) >= CMD_W);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      rd_q      <= 1'b0;
      ser_clk_o <= 1'b0;
      sel_n_o   <= 1'b1;
      oe_o      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q <= ST_LEAD;
          rd_q    <= rd_i;
          bit_q   <= '0;
          sel_n_o <= 1'b0;
          oe_o    <= 1'b1;
        end
        ST_LEAD: if (tick_i) begin
          state_q   <= ST_HIGH;
          ser_clk_o <= 1'b1;
        end
        ST_HIGH: begin
          if (release_pt) oe_o <= 1'b0;
          if (tick_i) begin
            ser_clk_o <= 1'b0;
            if (last_bit) state_q <= ST_TRAIL;
            else begin
              state_q <= ST_LOW;
              bit_q   <= bit_q + 1'b1;
            end
          end
        end
        ST_LOW: if (tick_i) begin
          state_q   <= ST_HIGH;
          ser_clk_o <= 1'b1;
        end
        ST_TRAIL: if (tick_i) begin
          state_q <= ST_DONE;
          sel_n_o <= 1'b1;
          oe_o    <= 1'b0;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_CLK_LOW_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_n_o |-> !ser_clk_o); // R2
  AST_READ_DRIVE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_HIGH || state_q == ST_LOW) && rd_q && int'(bit_q) >= CMD_W) |-> !oe_o); // R7
  AST_WRITE_DRIVE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_n_o && !rd_q) |-> oe_o); // R8
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && state_q != ST_LEAD) |=> state_q != ST_LEAD); // R9
  AST_DONE_DESELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sel_n_o); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R10
endmodule

// File: rtl/rfreg_spi_master.sv
`timescale 1ns/1ps
module rfreg_spi_master #(
  parameter int HALF_DIV = 13,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  localparam int CNT_W   = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ser_clk_o,
  output logic              reg_sel_n_o,
  output logic              fifo_sel_n_o,
  output logic              dat_o,
  output logic              dat_oe_o,
  input  logic              dat_i
);
  logic [CNT_W-1:0] cnt;
  logic tick, restart, load, shift, cap;

  assign fifo_sel_n_o = 1'b1;

  rfreg_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk_i, .rst_ni, .restart_i(restart), .cnt_o(cnt), .tick_o(tick)
  );

  rfreg_seq #(.HALF_DIV(HALF_DIV), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .req_i, .rd_i, .cnt_i(cnt), .tick_i(tick),
    .restart_o(restart), .load_o(load), .shift_o(shift), .cap_o(cap),
    .ser_clk_o, .sel_n_o(reg_sel_n_o), .oe_o(dat_oe_o), .busy_o, .done_o
  );

  rfreg_frame_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .load_i(load), .rd_i, .addr_i, .wdata_i,
    .shift_i(shift), .cap_i(cap), .dat_i, .bit_o(dat_o), .rdata_o
  );

  AST_FIFO_SEL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_sel_n_o |-> fifo_sel_n_o); // R1
  AST_DAT_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(dat_o)); // R4
  AST_SEL_EDGE_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(reg_sel_n_o) || $rose(reg_sel_n_o)) |-> !ser_clk_o); // R6
endmodule

// File: tb/rfreg_spi_master_bench.sv
`timescale 1ns/1ps
module rfreg_spi_master_bench;
  localparam int H    = 13;
  localparam int LAST = 33 * H;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, rd = 1'b0, dat_in = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic busy, done, ser_clk, reg_sel_n, fifo_sel_n, dat_out, dat_oe;
  logic [7:0] rdata;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rfreg_spi_master #(.HALF_DIV(H)) u_rfreg_spi_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .ser_clk_o(ser_clk), .reg_sel_n_o(reg_sel_n), .fifo_sel_n_o(fifo_sel_n),
    .dat_o(dat_out), .dat_oe_o(dat_oe), .dat_i(dat_in)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // timeline model: k_m = cycles since acceptance, -1 when idle
  int k_m = -1;
  logic [15:0] m_frame;
  logic m_rd;
  logic [7:0] m_byte;
  logic [7:0] dev_byte = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) k_m = -1;
    else if (k_m >= 0) k_m = (k_m == LAST) ? -1 : k_m + 1;
    else if (req) begin
      k_m = 0;
      m_frame = {rd, addr, wdata};
      m_rd = rd;
      m_byte = dev_byte;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int e_cs, e_sclk, e_oe, e_busy, e_done, e_dat;
      e_dat = 0;
      if (k_m < 0) begin
        e_cs = 1; e_sclk = 0; e_oe = 0; e_busy = 0; e_done = 0;
      end else if (k_m == LAST) begin
        e_cs = 1; e_sclk = 0; e_oe = 0; e_busy = 1; e_done = 1;
      end else begin
        int p, c, b;
        p = k_m / H; c = k_m % H; b = p / 2;
        e_cs = 0; e_busy = 1; e_done = 0;
        e_sclk = ((p % 2) == 1 && p <= 31) ? 1 : 0;
        e_oe = m_rd ? ((p < 15 || (p == 15 && c <= H / 2)) ? 1 : 0) : 1;
        e_dat = (b < 16) ? int'(m_frame[15 - b]) : 0;
      end
      chk("R1 fifo select", int'(fifo_sel_n), 1);
      chk("R6 register select timing", int'(reg_sel_n), e_cs);
      chk("R5 serial clock phase", int'(ser_clk), e_sclk);
      chk((k_m >= 0 && m_rd) ? "R7 read drive release" : "R8 drive enable", int'(dat_oe), e_oe);
      chk("R9 busy", int'(busy), e_busy);
      chk("R10 done pulse", int'(done), e_done);
      if (e_oe == 1) chk("R4 data bit", int'(dat_out), e_dat);
      if (e_done == 1) chk("R10 read data at done", int'(rdata), m_rd ? int'(m_byte) : 0);
    end
  end

  // transceiver model on the serial pins
  logic [15:0] dev_rx;
  int dev_rises = 0, dev_falls = 0;
  bit dev_armed = 0, dev_rd = 0;

  always @(negedge reg_sel_n) begin
    dev_rises = 0; dev_falls = 0; dev_rd = 0; dev_armed = 1; dat_in = 1'b0;
  end
  always @(posedge ser_clk) begin
    dev_rx = {dev_rx[14:0], dat_out};
    dev_rises++;
  end
  always @(negedge ser_clk) begin
    dev_falls++;
    if (dev_falls == 8) dev_rd = dev_rx[7];
    if (dev_rd && dev_falls >= 8 && dev_falls < 16) dat_in = dev_byte[15 - dev_falls];
  end
  always @(posedge reg_sel_n) begin
    if (dev_armed && rst_n) begin
      dev_armed = 0;
      chk("R3 rising edge count", dev_rises, 16);
      chk("R3 received frame", int'(dev_rx), int'(m_frame));
    end
  end

  task automatic xfer(input logic r, input logic [6:0] a, input logic [7:0] d, input logic [7:0] rb);
    while (busy) @(negedge clk);
    rd = r; addr = a; wdata = d; dev_byte = rb; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk("R2 reset select", int'(reg_sel_n), 1);
    chk("R2 reset clock", int'(ser_clk), 0);
    chk("R2 reset drive", int'(dat_oe), 0);
    chk("R2 reset busy", int'(busy), 0);
    chk("R2 reset done", int'(done), 0);

    xfer(1'b0, 7'h2A, 8'hC5, 8'h00);
    xfer(1'b1, 7'h55, 8'h00, 8'h3C);
    xfer(1'b1, 7'h7F, 8'hA5, 8'hFF);
    xfer(1'b0, 7'h00, 8'h00, 8'h00);
    xfer(1'b1, 7'h01, 8'h00, 8'h80);
    xfer(1'b0, 7'h40, 8'h01, 8'h5A);

    // R9: request during an active write has no effect
    rd = 1'b0; addr = 7'h13; wdata = 8'h9E; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (100) @(negedge clk);
    rd = 1'b1; addr = 7'h6C; wdata = 8'h11; dev_byte = 8'hE7; req = 1'b1;
    repeat (40) @(negedge clk);
    req = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R9 idle after ignored request", int'(busy), 0);

    // R9/R10: request held through done starts the next frame one cycle later
    rd = 1'b1; addr = 7'h33; wdata = 8'h00; dev_byte = 8'h69; req = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    while (!done) @(negedge clk);
    req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 idle between frames", int'(reg_sel_n), 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule